// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block counts a loaded value down to zero at a rate set by a power-of-two prescaler on the bus clock. Software writes three registers through a single write port: the initial count, a 4-bit divide configuration and a control word. The control word holds an 8-bit vector, a mask bit, a periodic-mode bit and one stored status bit. The current count and the control word can be read back at any time.

Each expiry produces an edge-style interrupt request that carries the vector from the control word. Expiries that arrive while the mask is clear are counted in a small backlog. Requests are then offered one at a time on a valid/ready pair, so a receiver that is busy for a while still sees every expiry.

Top module: `div_countdown_timer`

## Requirements
- R1: The divisor is 2^s, where s = ({cfg[3], cfg[1], cfg[0]} + 1) mod 8. Code 111 gives divide-by-1, 000 gives divide-by-2, 001 gives divide-by-4, 100 gives divide-by-32 and 110 gives divide-by-128. The divide configuration is written with wr_sel = 1, using wr_data[3:0].
- R2: Bit 2 of the divide configuration has no effect on the divisor.
- R3: A write with wr_sel = 0 loads wr_data into both the initial and the current count and restarts the prescaler. After w clock edges following the write edge, a one-shot count reads N - floor(w / divisor), bounded below by zero.
- R4: With an initial count of zero, the count reads zero and no request is ever raised.
- R5: In one-shot mode the count stays at zero after expiry until the initial count is written again, and there is no further request.
- R6: In periodic mode (control bit 17 set), a decrement from 1 reloads the initial count instead of reaching zero, and the count keeps running.
- R7: An expiry with the mask (control bit 16) clear raises irq_valid in the cycle after the expiring edge, with irq_vector equal to control bits [7:0]. Expiries that occur while the mask is set are dropped.
- R8: Only control bits 17, 16, 12 and 7:0 are stored, so the control word reads back as the written value AND 0x000310FF. The control word is written with wr_sel = 2. After reset it reads 0x00010000.
- R9: Unaccepted expiries are held in a backlog that saturates at 2^BACKLOG_W - 1. irq_valid stays high while the backlog is non-empty. Each cycle with irq_valid and irq_ready both high consumes exactly one entry.
- R10: Reset clears the initial count, the current count, the divide configuration (giving divide-by-2) and the backlog.
- R11: A write with wr_sel = 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 divide, 2 control, 3 none |
| wr_data | input | 32 | Write data |
| rd_count | output | CNT_W | Current count |
| rd_ctrl | output | 32 | Stored control word |
| irq_valid | output | 1 | Interrupt request pending |
| irq_vector | output | 8 | Vector carried by the request |
| irq_ready | input | 1 | Receiver accepts the request this cycle |

## Verification
The bench builds the block with CNT_W = 32 and BACKLOG_W = 3. With these values the backlog saturates at seven entries, which a periodic count of one reaches within about a dozen cycles. It also uses the divide-by-128 code, so the slowest prescaler setting is exercised in a few hundred cycles. Periodic counts of 2 and 3 reach several reloads in short windows, and the count of zero and the one-shot stop are both covered.

// File: rtl/dct_pkg.sv
// Package: shared widths, register selects and control-word layout for the
// divided countdown timer. Assumes a 32-bit register write port.
package dct_pkg;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;
    localparam int SH_W   = 3;

    typedef enum logic [1:0] {
        SEL_INIT = 2'd0,
        SEL_DIV  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_PER_BIT  = 17;
    localparam logic [DATA_W-1:0] CTRL_WR_MASK = 32'h0003_10FF;
    localparam logic [DATA_W-1:0] CTRL_RST     = 32'h0001_0000;

    // Divide code: bits 3,1,0 form a 3-bit value; plus one, modulo 8.
    function automatic logic [SH_W-1:0] div_shift(input logic [3:0] cfg);
        return {cfg[3], cfg[1:0]} + 3'd1;
    endfunction
endpackage

// File: rtl/dct_prescaler.sv
// Prescaler: emits one tick every 2^shift clocks. The restart input zeroes
// the phase so that a new count begins a full divisor period later.
// Assumes shift < 2^SH_W and that a tick is never wanted during restart.
module dct_prescaler #(
    parameter int SH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [SH_W-1:0] shift,
    output logic            tick
);
    localparam int PRE_W = (1 << SH_W) - 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W:0]   span;
    logic [PRE_W:0]   limit_w;

    // Terminal phase value for the selected divisor.
    always_comb begin
        span    = {{PRE_W{1'b0}}, 1'b1} << shift;
        limit_w = span - {{PRE_W{1'b0}}, 1'b1};
        tick    = !restart && (phase_q >= limit_w[PRE_W-1:0]);
    end

    // Phase counter: wraps on tick, zeroed on restart or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shift != '0) |=> (!tick || shift == '0));
endmodule

// File: rtl/dct_counter.sv
// Counter: holds the initial and current count. Decrements on prescaler
// ticks, flags expiry on the 1->0 step, and reloads in periodic mode.
// Assumes load takes priority over a tick in the same cycle.
module dct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cur_q;

    // Expiry occurs when a tick consumes the last unit of the count.
    always_comb begin
        expire = tick && !load && (cur_q == ONE);
        cur    = cur_q;
    end

    // Count state: load, decrement, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            init_q <= load_val;
            cur_q  <= load_val;
        end else if (tick && cur_q != '0) begin
            if (cur_q == ONE)
                cur_q <= periodic ? init_q : '0;
            else
                cur_q <= cur_q - ONE;
        end
    end

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == '0 && !load) |=> (cur_q == '0));
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= init_q);
    // R6
    expire_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cur_q == '0 || cur_q == init_q));
endmodule

// File: rtl/dct_irq_queue.sv
// Request queue: counts unmasked expiries and offers them one per accepted
// cycle on a valid/ready pair. Saturates instead of wrapping.
// Assumes the mask is sampled in the same cycle as the expiry.
module dct_irq_queue #(
    parameter int BACKLOG_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic masked,
    input  logic ready,
    output logic valid
);
    localparam logic [BACKLOG_W-1:0] FULL = {BACKLOG_W{1'b1}};

    logic [BACKLOG_W-1:0] backlog_q;
    logic                 push;
    logic                 pop;

    // Request handshake terms.
    always_comb begin
        valid = (backlog_q != '0);
        push  = expire && !masked;
        pop   = valid && ready;
    end

    // Backlog update: net change of push minus pop, clamped at full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            backlog_q <= '0;
        else if (push && !pop && backlog_q != FULL)
            backlog_q <= backlog_q + 1'b1;
        else if (pop && !push)
            backlog_q <= backlog_q - 1'b1;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid);
    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog_q == FULL && !ready) |=> (backlog_q == FULL));
    // R7
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && backlog_q != FULL) |=> (backlog_q <= $past(backlog_q)));
endmodule

// File: rtl/div_countdown_timer.sv
// Top: register write decode, control word storage and the wiring of
// prescaler, counter and request queue. Assumes single-cycle writes and
// a combinational read of the count and control word.
module div_countdown_timer
    import dct_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int BACKLOG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  rd_count,
    output logic [DATA_W-1:0] rd_ctrl,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ready
);
    logic [3:0]        div_cfg_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              load;
    logic              tick;
    logic              expire;
    logic [SH_W-1:0]   shift;
    reg_sel_e          sel;

    // Write decode and divisor selection.
    always_comb begin
        sel        = reg_sel_e'(wr_sel);
        load       = wr_en && (sel == SEL_INIT);
        shift      = div_shift(div_cfg_q);
        rd_ctrl    = ctrl_q;
        irq_vector = ctrl_q[VEC_W-1:0];
    end

    // Configuration registers: divide code and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cfg_q <= '0;
            ctrl_q    <= CTRL_RST;
        end else if (wr_en) begin
            if (sel == SEL_DIV)
                div_cfg_q <= wr_data[3:0];
            else if (sel == SEL_CTRL)
                ctrl_q <= wr_data & CTRL_WR_MASK;
        end
    end

    dct_prescaler #(.SH_W(SH_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (shift),
        .tick    (tick)
    );

    dct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .periodic (ctrl_q[CTRL_PER_BIT]),
        .cur      (rd_count),
        .expire   (expire)
    );

    dct_irq_queue #(.BACKLOG_W(BACKLOG_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .masked (ctrl_q[CTRL_MASK_BIT]),
        .ready  (irq_ready),
        .valid  (irq_valid)
    );

    // R8
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WR_MASK) == '0);
    // R11
    sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> $stable(ctrl_q) && $stable(div_cfg_q));
endmodule

// File: tb/div_countdown_timer_tb_top.sv
module div_countdown_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_count;
    logic [31:0] rd_ctrl;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    div_countdown_timer #(.CNT_W(32), .BACKLOG_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_count(rd_count), .rd_ctrl(rd_ctrl),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ready(irq_ready)
    );

    // {div[3:0], init[31:0], periodic, wait[15:0], expected[31:0]}
    localparam int NV = 10;
    localparam logic [84:0] VECS [0:NV-1] = '{
        {4'hB, 32'd10,  1'b0, 16'd3,   32'd7},   // R1 div1
        {4'h0, 32'd10,  1'b0, 16'd5,   32'd8},   // R1 div2
        {4'h1, 32'd100, 1'b0, 16'd9,   32'd98},  // R1 div4
        {4'h4, 32'd20,  1'b0, 16'd7,   32'd17},  // R2 bit2 ignored
        {4'hA, 32'd3,   1'b0, 16'd300, 32'd1},   // R1 div128
        {4'h8, 32'd5,   1'b0, 16'd64,  32'd3},   // R1 div32
        {4'hB, 32'd4,   1'b0, 16'd10,  32'd0},   // R5 stays zero
        {4'hB, 32'd4,   1'b1, 16'd10,  32'd2},   // R6 reload
        {4'hB, 32'd0,   1'b0, 16'd5,   32'd0},   // R4 zero count
        {4'h0, 32'd3,   1'b1, 16'd13,  32'd3}    // R6 reload div2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int cnt;
        bit seen;
        repeat (3) @(negedge clk);
        // R10 reset state, R8 reset control
        check("R10 count", rd_count, 32'd0);
        check("R8 ctrl reset", rd_ctrl, 32'h0001_0000);
        check("R10 valid", {31'd0, irq_valid}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(2'd1, {28'd0, VECS[i][84:81]});
            wr(2'd2, 32'h0001_0000 | ({31'd0, VECS[i][48]} << 17));
            wr(2'd0, VECS[i][80:49]);
            repeat (int'(VECS[i][47:32])) @(negedge clk);
            check($sformatf("R3 vector %0d", i), rd_count, VECS[i][31:0]);
        end

        // R8 writable bits
        wr(2'd0, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF);
        check("R8 ctrl mask", rd_ctrl, 32'h0003_10FF);

        // R11 select 3 ignored
        wr(2'd2, 32'h0001_0000);
        wr(2'd1, 32'h0000_000A);
        wr(2'd0, 32'd100);
        wr(2'd3, 32'hFFFF_FFFF);
        check("R11 ctrl", rd_ctrl, 32'h0001_0000);
        check("R11 count", rd_count, 32'd100);

        // R7 request with vector, one-shot single expiry
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h0000_0042);
        wr(2'd1, 32'h0000_000B);
        irq_ready = 1'b1;
        wr(2'd0, 32'd3);
        repeat (3) @(negedge clk);
        check("R7 valid", {31'd0, irq_valid}, 32'd1);
        check("R7 vector", {24'd0, irq_vector}, 32'h42);
        @(negedge clk);
        check("R7 accepted", {31'd0, irq_valid}, 32'd0);
        seen = 1'b0;
        repeat (6) begin @(negedge clk); if (irq_valid) seen = 1'b1; end
        check("R5 no repeat", {31'd0, seen}, 32'd0);

        // R7 masked expiries dropped
        wr(2'd2, 32'h0001_0042);
        wr(2'd0, 32'd2);
        seen = 1'b0;
        repeat (8) begin @(negedge clk); if (irq_valid) seen = 1'b1; end
        check("R7 masked", {31'd0, seen}, 32'd0);

        // R4 zero count never requests
        wr(2'd2, 32'h0002_0042);
        wr(2'd0, 32'd0);
        seen = 1'b0;
        repeat (8) begin @(negedge clk); if (irq_valid) seen = 1'b1; end
        check("R4 no request", {31'd0, seen}, 32'd0);

        // R9 backlog of three, replayed one per cycle
        irq_ready = 1'b0;
        wr(2'd0, 32'd2);
        repeat (6) @(negedge clk);
        check("R9 held", {31'd0, irq_valid}, 32'd1);
        wr(2'd0, 32'd0);
        irq_ready = 1'b1;
        cnt = 0;
        repeat (10) begin if (irq_valid) cnt++; @(negedge clk); end
        check("R9 replay", cnt, 32'd3);

        // R9 saturation at 7
        irq_ready = 1'b0;
        wr(2'd0, 32'd1);
        repeat (12) @(negedge clk);
        wr(2'd0, 32'd0);
        irq_ready = 1'b1;
        cnt = 0;
        repeat (12) begin if (irq_valid) cnt++; @(negedge clk); end
        check("R9 saturate", cnt, 32'd7);

        // R10 reset mid-run, divide returns to div2
        wr(2'd1, 32'h0000_000B);
        wr(2'd0, 32'd50);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 count cleared", rd_count, 32'd0);
        check("R10 ctrl masked", rd_ctrl, 32'h0001_0000);
        rst_n = 1'b1;
        wr(2'd0, 32'd10);
        repeat (4) @(negedge clk);
        check("R10 divide cleared", rd_count, 32'd8);

        finish_run();
    end
endmodule